// File: doc/BRIEF.md
# PC Card Configuration and Port Decoder

This block sits between a PC card's host bus and its internal functions. Each host access is either an attribute-memory access or an I/O access. For attribute accesses, address bit 10 picks the target. When the bit is clear, the card information ROM is selected, so that ROM is mirrored in every other 1K window. When the bit is set, an internal 8-bit configuration option register is selected. That register answers at every byte address of its window.

The configuration option register gates the card's I/O. Only one value in its low six bits, 0x01, enables the I/O side. Writing its top bit as 1 starts a soft reset, which holds the lower seven bits at zero. Returning that bit to zero takes a separate write, and that write does not load the lower bits. While the card is enabled, address bits 2..0 of an I/O access select one of eight ports. The block then raises a one-hot read or write strobe for that port and returns the addressed port's read data to the host. Port 6 is write-only.

All selects and strobes are combinational from the address and the access enables. Only the option register is clocked.

Top module: `pccard_cfg_decode`

## Requirements
- R1: An attribute read or write with address bit 10 clear asserts `rom_cs` and leaves `cor_cs` low, for any value of the other address bits.
- R2: An attribute access with address bit 10 set asserts `cor_cs` at every byte address of the window. Writes there update the register whatever the low address bits are.
- R3: `rom_cs` and `cor_cs` respond to attribute accesses whether or not the card is enabled.
- R4: `cfg_en` is high exactly when register bits 5..0 equal 0x01. Bit 6 has no effect on it, and any other value of bits 5..0 keeps I/O disabled.
- R5: After a hardware reset (`rst_n` low) the register reads 0x00, `cfg_en` is low and `soft_rst` is low.
- R6: An attribute write to the register with data bit 7 set leaves the register at 0x80 from the next cycle. `soft_rst` is high from that cycle, and further writes with bit 7 set keep bits 6..0 at zero.
- R7: A register write with data bit 7 clear, made while bit 7 is set, leaves the register at 0x00 whatever the data. Only a later write loads configuration data.
- R8: While enabled, an I/O read or write raises exactly the strobe bit whose index equals address bits 2..0 in `io_rd_stb` or `io_wr_stb`. Read and write decode independently.
- R9: An I/O read of port 6 raises no read strobe and returns 0x00 on `host_rdata`. An I/O write to port 6 strobes normally.
- R10: While disabled, I/O accesses raise no strobe and `host_rdata` is 0x00 for I/O reads.
- R11: An attribute read of the register returns its 8-bit contents on `host_rdata`. An enabled I/O read of any port other than 6 returns `port_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| addr | input | ADDR_W | Host address |
| att_rd | input | 1 | Attribute-space read enable |
| att_wr | input | 1 | Attribute-space write enable |
| io_rd | input | 1 | I/O-space read enable |
| io_wr | input | 1 | I/O-space write enable |
| wdata | input | 8 | Host write data |
| port_rdata | input | 8 | Read data from the addressed I/O port |
| rom_cs | output | 1 | Information ROM select |
| cor_cs | output | 1 | Configuration register select |
| io_rd_stb | output | 8 | One-hot I/O read strobes, index = port |
| io_wr_stb | output | 8 | One-hot I/O write strobes, index = port |
| host_rdata | output | 8 | Read data returned to the host |
| cfg_en | output | 1 | Card I/O enabled |
| soft_rst | output | 1 | Soft reset level (register bit 7) |

## Verification
A wrong register value shows on the ports in the cycle after the write that caused it. It can appear as a wrong `cfg_en`, strobes that are present or missing on the next I/O access, or a stale value on a register read. A missed clear during soft reset shows up in the same way. A register that loaded data on the write that clears bit 7 would raise `cfg_en` one cycle early. Decode errors show on the strobes and selects in the same cycle as the access. For this reason every access is compared in its own cycle against a model of the register.

// File: rtl/pccard_cfg_pkg.sv
package pccard_cfg_pkg;
  localparam int DATA_W     = 8;
  localparam int NPORT      = 8;
  localparam int PORT_SEL_W = $clog2(NPORT);
  localparam int WO_PORT    = 6;
  localparam int CFG_LOW_W  = 6;
  localparam logic [CFG_LOW_W-1:0] CFG_VALUE = 6'h01;
  localparam logic [DATA_W-1:0]    SRST_VALUE = 8'h80;
endpackage

// File: rtl/attr_window_dec.sv
module attr_window_dec #(
  parameter int ADDR_W  = 12,
  parameter int WIN_BIT = 10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              att_rd,
  input  logic              att_wr,
  output logic              rom_sel,
  output logic              reg_sel
);
  logic att_any;
  always_comb begin
    att_any = att_rd | att_wr;
    rom_sel = att_any & ~addr[WIN_BIT];
    reg_sel = att_any &  addr[WIN_BIT];
  end
endmodule

// File: rtl/cfg_option_reg.sv
module cfg_option_reg
  import pccard_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] value,
  output logic              enable,
  output logic              srst
);
  logic [DATA_W-1:0] value_q, value_d;

  // Bit 7 set forces the low bits clear; a write that drops bit 7 loads nothing.
  always_comb begin
    value_d = value_q;
    if (wr_en) begin
      if (wdata[DATA_W-1])       value_d = SRST_VALUE;
      else if (value_q[DATA_W-1]) value_d = '0;
      else                        value_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value_q <= '0;
    else        value_q <= value_d;
  end

  always_comb begin
    value  = value_q;
    enable = (value_q[CFG_LOW_W-1:0] == CFG_VALUE);
    srst   = value_q[DATA_W-1];
  end
endmodule

// File: rtl/io_port_dec.sv
module io_port_dec
  import pccard_cfg_pkg::*;
(
  input  logic [PORT_SEL_W-1:0] sel,
  input  logic                  enable,
  input  logic                  rd,
  input  logic                  wr,
  output logic [NPORT-1:0]      rd_stb,
  output logic [NPORT-1:0]      wr_stb
);
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam bit READABLE = (p != WO_PORT);
    assign rd_stb[p] = READABLE & enable & rd & (sel == PORT_SEL_W'(p));
    assign wr_stb[p] = enable & wr & (sel == PORT_SEL_W'(p));
  end
endmodule

// File: rtl/pccard_cfg_decode.sv
module pccard_cfg_decode
  import pccard_cfg_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int WIN_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              att_rd,
  input  logic              att_wr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [7:0]        wdata,
  input  logic [7:0]        port_rdata,
  output logic              rom_cs,
  output logic              cor_cs,
  output logic [7:0]        io_rd_stb,
  output logic [7:0]        io_wr_stb,
  output logic [7:0]        host_rdata,
  output logic              cfg_en,
  output logic              soft_rst
);
  logic [DATA_W-1:0] reg_value;
  logic              reg_wr;

  attr_window_dec #(.ADDR_W(ADDR_W), .WIN_BIT(WIN_BIT)) u_attr (
    .addr(addr), .att_rd(att_rd), .att_wr(att_wr),
    .rom_sel(rom_cs), .reg_sel(cor_cs)
  );

  assign reg_wr = att_wr & addr[WIN_BIT];

  cfg_option_reg u_cor (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wdata(wdata),
    .value(reg_value), .enable(cfg_en), .srst(soft_rst)
  );

  io_port_dec u_io (
    .sel(addr[PORT_SEL_W-1:0]), .enable(cfg_en), .rd(io_rd), .wr(io_wr),
    .rd_stb(io_rd_stb), .wr_stb(io_wr_stb)
  );

  always_comb begin
    if (att_rd && addr[WIN_BIT])  host_rdata = reg_value;
    else if (|io_rd_stb)          host_rdata = port_rdata;
    else                          host_rdata = '0;
  end
endmodule

// File: rtl/pccard_cfg_decode_chk.sv
module pccard_cfg_decode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       att_rd,
  input logic       io_rd,
  input logic       rom_cs,
  input logic       cor_cs,
  input logic [7:0] io_rd_stb,
  input logic [7:0] io_wr_stb,
  input logic [7:0] host_rdata,
  input logic       cfg_en,
  input logic       soft_rst
);
  // R1
  win_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_cs && cor_cs));
  // R8
  rd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(io_rd_stb));
  // R8
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(io_wr_stb));
  // R9
  wo_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd_stb[6]);
  // R10
  gated_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> (io_rd_stb == 8'h00 && io_wr_stb == 8'h00));
  // R10
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && io_rd && !att_rd) |-> host_rdata == 8'h00);
  // R6
  srst_low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && att_rd && cor_cs) |-> host_rdata[6:0] == 7'h00);
  // R6
  srst_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> !cfg_en);
  // R7
  release_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(soft_rst) |-> !cfg_en);
endmodule

bind pccard_cfg_decode pccard_cfg_decode_chk u_chk (
  .clk(clk), .rst_n(rst_n), .att_rd(att_rd), .io_rd(io_rd),
  .rom_cs(rom_cs), .cor_cs(cor_cs), .io_rd_stb(io_rd_stb),
  .io_wr_stb(io_wr_stb), .host_rdata(host_rdata),
  .cfg_en(cfg_en), .soft_rst(soft_rst)
);

// File: tb/sim_pccard_cfg_decode.sv
`timescale 1ns/1ps
module sim_pccard_cfg_decode;
  typedef enum logic [2:0] {K_IDLE, K_ARD, K_AWR, K_IRD, K_IWR} kind_t;
  typedef struct {
    string      tag;
    logic       rom;
    logic       cor;
    logic [7:0] rd;
    logic [7:0] wr;
    logic [7:0] rdata;
    logic       en;
    logic       srst;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic [11:0] addr = '0;
  logic att_rd = 0, att_wr = 0, io_rd = 0, io_wr = 0;
  logic [7:0] wdata = '0, port_rdata = 8'hA5;
  logic rom_cs, cor_cs, cfg_en, soft_rst;
  logic [7:0] io_rd_stb, io_wr_stb, host_rdata;

  int n_run = 0, n_fail = 0;
  exp_t q[$];
  logic [7:0] model = 8'h00;
  bit done = 0;

  always #2.5 clk = ~clk;

  pccard_cfg_decode u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .att_rd(att_rd), .att_wr(att_wr),
    .io_rd(io_rd), .io_wr(io_wr), .wdata(wdata), .port_rdata(port_rdata),
    .rom_cs(rom_cs), .cor_cs(cor_cs), .io_rd_stb(io_rd_stb),
    .io_wr_stb(io_wr_stb), .host_rdata(host_rdata),
    .cfg_en(cfg_en), .soft_rst(soft_rst)
  );

  task automatic push_exp(input kind_t k, input logic [11:0] a, input string tag);
    exp_t e;
    logic att, win, en;
    logic [2:0] p;
    att = (k == K_ARD) || (k == K_AWR);
    win = a[10];
    en  = (model[5:0] == 6'h01);
    p   = a[2:0];
    e.tag  = tag;
    e.rom  = att && !win;
    e.cor  = att && win;
    e.rd   = (k == K_IRD && en && p != 3'd6) ? (8'h01 << p) : 8'h00;
    e.wr   = (k == K_IWR && en) ? (8'h01 << p) : 8'h00;
    e.rdata = (k == K_ARD && win) ? model :
              (k == K_IRD && en && p != 3'd6) ? port_rdata : 8'h00;
    e.en   = en;
    e.srst = model[7];
    q.push_back(e);
  endtask

  task automatic access(input kind_t k, input logic [11:0] a,
                        input logic [7:0] w, input string tag);
    @(negedge clk);
    addr = a; wdata = w;
    att_rd = (k == K_ARD); att_wr = (k == K_AWR);
    io_rd  = (k == K_IRD); io_wr  = (k == K_IWR);
    push_exp(k, a, tag);
    if (k == K_AWR && a[10])
      model = w[7] ? 8'h80 : (model[7] ? 8'h00 : w);
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst_n = 0; att_rd = 0; att_wr = 0; io_rd = 0; io_wr = 0;
    model = 8'h00;
    push_exp(K_IDLE, 12'h000, "R5");
    @(negedge clk);
    rst_n = 1;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_run++;
        if (rom_cs !== e.rom || cor_cs !== e.cor || io_rd_stb !== e.rd ||
            io_wr_stb !== e.wr || host_rdata !== e.rdata ||
            cfg_en !== e.en || soft_rst !== e.srst) begin
          n_fail++;
          $display("FAIL %s: got rom=%b cor=%b rd=%h wr=%h rdata=%h en=%b srst=%b exp rom=%b cor=%b rd=%h wr=%h rdata=%h en=%b srst=%b",
            e.tag, rom_cs, cor_cs, io_rd_stb, io_wr_stb, host_rdata, cfg_en, soft_rst,
            e.rom, e.cor, e.rd, e.wr, e.rdata, e.en, e.srst);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R5 reset state while held in reset
    @(negedge clk);
    push_exp(K_IDLE, 12'h000, "R5");
    repeat (2) @(negedge clk);
    rst_n = 1;
    access(K_ARD, 12'h400, 8'h00, "R5");
    // R1 ROM windows, R3 while disabled
    access(K_ARD, 12'h123, 8'h00, "R1");
    access(K_ARD, 12'h9FF, 8'h00, "R1");
    access(K_AWR, 12'hB00, 8'h01, "R1");
    access(K_ARD, 12'h5A7, 8'h00, "R3");
    // R10 disabled I/O
    access(K_IWR, 12'h003, 8'h00, "R10");
    access(K_IRD, 12'h001, 8'h00, "R10");
    // R4 invalid config values
    access(K_AWR, 12'h400, 8'h02, "R4");
    access(K_IRD, 12'h002, 8'h00, "R4");
    access(K_AWR, 12'h400, 8'h21, "R4");
    access(K_IWR, 12'h004, 8'h00, "R4");
    // R2 mirrored byte address, bit 6 ignored for R4
    access(K_AWR, 12'h7FF, 8'h41, "R2");
    access(K_ARD, 12'h6C3, 8'h00, "R11");
    access(K_AWR, 12'h4D5, 8'h01, "R2");
    access(K_ARD, 12'h401, 8'h00, "R11");
    // R3 ROM still selected while enabled
    access(K_ARD, 12'h050, 8'h00, "R3");
    // R8 every port, both directions; R9 port 6
    for (int p = 0; p < 8; p++) begin
      port_rdata = 8'h30 + 8'(p);
      access(K_IRD, 12'h0F8 | 12'(p), 8'h00, p == 6 ? "R9" : "R8");
      access(K_IWR, 12'h0F8 | 12'(p), 8'h00, p == 6 ? "R9" : "R8");
    end
    // R6 soft reset
    access(K_AWR, 12'h400, 8'h81, "R6");
    access(K_ARD, 12'h400, 8'h00, "R6");
    access(K_IWR, 12'h002, 8'h00, "R6");
    access(K_AWR, 12'h410, 8'hFF, "R6");
    access(K_ARD, 12'h400, 8'h00, "R6");
    // R7 release write does not load
    access(K_AWR, 12'h400, 8'h01, "R7");
    access(K_ARD, 12'h400, 8'h00, "R7");
    access(K_IRD, 12'h000, 8'h00, "R7");
    access(K_AWR, 12'h400, 8'h01, "R7");
    access(K_IRD, 12'h005, 8'h00, "R7");
    // R5 hardware reset mid-run
    hw_reset();
    access(K_ARD, 12'h400, 8'h00, "R5");
    access(K_IWR, 12'h001, 8'h00, "R5");
    access(K_IDLE, 12'h000, 8'h00, "R5");
    repeat (4) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule